// File: doc/BRIEF.md
# Scan-Testable Three-Bit Counter

This block is a small synchronous up-counter whose state registers are built as multiplexed scan cells. In functional operation it increments by one on each clock while its enable is high, holds while the enable is low, and returns to zero on a synchronous clear. In test operation the same registers are chained into a serial shift path. A tester can then place any state into the counter, apply a single functional clock, and read the result back serially.

The increment logic is a ripple of AND gates (the carry) and XOR gates (the sum). The scan path turns the test of that sequential logic into a combinational one. A single capture clock checks the next-state function for any chosen state and enable value. A carry line that is stuck is exposed by a wrong bit at the serial output.

Top module: `scnt_top`

## Requirements
- R1: When `sync_clr` is 1 at a rising clock edge, every bit of `count_q` becomes 0 at that edge. This holds whatever the values of `scan_mode` and `cnt_en`.
- R2: With `sync_clr`=0, `scan_mode`=0 and `cnt_en`=1, each edge adds one to `count_q` modulo 8, so 7 is followed by 0.
- R3: With `sync_clr`=0, `scan_mode`=0 and `cnt_en`=0, `count_q` keeps its value across the edge.
- R4: With `sync_clr`=0 and `scan_mode`=1, each edge shifts the state one place toward the most significant bit. `scan_din` enters bit 0, bit 0 moves to bit 1 and bit 1 moves to bit 2. `cnt_en` has no effect in this mode.
- R5: `scan_dout` always presents bit 2 of the state, the last cell of the chain.
- R6: A capture works as follows. Three shifts with `scan_din` carrying bit 2, then bit 1, then bit 0 load a value V. One edge in functional mode then follows. After it, the state equals V+1 mod 8 when `cnt_en`=1 and V when `cnt_en`=0. For V=3 with `cnt_en`=1, bit 2 becomes 1, which a broken carry into bit 2 would leave at 0.
- R7: After a capture, further shift edges present the captured value at `scan_dout` most significant bit first. Bit 2 is present before the first shift, bit 1 after one shift and bit 0 after two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| cnt_en | input | 1 | Count enable in functional mode |
| sync_clr | input | 1 | Synchronous clear to zero; has priority over every mode |
| scan_mode | input | 1 | 1 selects serial shift, 0 selects functional next-state load |
| scan_din | input | 1 | Serial data into bit 0 |
| count_q | output | 3 | Counter state |
| scan_dout | output | 1 | Serial data out, taken from bit 2 |

## Verification
The hardest condition to reach from the ports is a functional capture from an arbitrary state with a chosen enable. Counting alone reaches each state only in order, and always with the enable high. The bench therefore loads each of the eight states serially and applies one capture edge with the enable low, then repeats with the enable high. It unloads every result through `scan_dout`. In this way both the carry chain and the hold path are exercised from every starting point. This includes state 3, whose increment depends on the full carry into bit 2.

// File: rtl/scnt_pkg.sv
package scnt_pkg;

    // Operation applied to the state register on the next edge, in priority order
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_SHIFT = 2'd1,
        OP_FUNC  = 2'd2
    } scnt_op_e;

    function automatic scnt_op_e pick_op(input logic clr, input logic scan);
        if (clr)       return OP_CLEAR;
        else if (scan) return OP_SHIFT;
        else           return OP_FUNC;
    endfunction

endpackage

// File: rtl/scnt_next.sv
// Ripple next-state logic: sum bit is XOR of carry and state, carry is AND
module scnt_next #(
    parameter int W = 3
) (
    input  logic         en,
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    logic [W:0] carry;

    assign carry[0] = en;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign nxt[i]     = carry[i] ^ cur[i];
        assign carry[i+1] = carry[i] & cur[i];
    end

    logic unused_carry;
    assign unused_carry = carry[W];
endmodule

// File: rtl/scnt_shift.sv
// Serial path: input enters the low cell, each cell feeds the next one up
module scnt_shift #(
    parameter int W = 3
) (
    input  logic         sin,
    input  logic [W-1:0] cur,
    output logic [W-1:0] shifted,
    output logic         sout
);
    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign shifted[i] = sin;
        end else begin : g_link
            assign shifted[i] = cur[i-1];
        end
    end

    assign sout = cur[W-1];
endmodule

// File: rtl/scnt_top.sv
module scnt_top
    import scnt_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         cnt_en,
    input  logic         sync_clr,
    input  logic         scan_mode,
    input  logic         scan_din,
    output logic [W-1:0] count_q,
    output logic         scan_dout
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } scnt_state_t;

    scnt_state_t  state_d, state_q;
    logic [W-1:0] func_d;
    logic [W-1:0] shift_d;
    scnt_op_e     op_d;

    scnt_next #(.W(W)) u_next (
        .en  (cnt_en),
        .cur (state_q.cnt),
        .nxt (func_d)
    );

    scnt_shift #(.W(W)) u_shift (
        .sin     (scan_din),
        .cur     (state_q.cnt),
        .shifted (shift_d),
        .sout    (scan_dout)
    );

    always_comb begin
        op_d    = pick_op(sync_clr, scan_mode);
        state_d = state_q;
        case (op_d)
            OP_CLEAR: state_d.cnt = '0;
            OP_SHIFT: state_d.cnt = shift_d;
            default:  state_d.cnt = func_d;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count_q = state_q.cnt;

    // Clear wins over every mode
    assert_clear_zero_R1: assert property (@(posedge clk)
        sync_clr |=> (count_q == '0));

    // Functional increment with wrap
    assert_count_step_R2: assert property (@(posedge clk) disable iff (sync_clr)
        (!scan_mode && cnt_en) |=> (count_q == $past(count_q) + W'(1)));

    // Functional hold
    assert_hold_R3: assert property (@(posedge clk) disable iff (sync_clr)
        (!scan_mode && !cnt_en) |=> $stable(count_q));

    // Serial shift toward the top cell
    assert_shift_R4: assert property (@(posedge clk) disable iff (sync_clr)
        scan_mode |=> (count_q == {$past(count_q[W-2:0]), $past(scan_din)}));

    // Serial output follows the cell below the top one after a shift
    assert_sout_R5: assert property (@(posedge clk) disable iff (sync_clr)
        scan_mode |=> (scan_dout == $past(count_q[W-2])));
endmodule

// File: tb/scnt_top_bench.sv
module scnt_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       cnt_en = 1'b0;
    logic       sync_clr = 1'b1;
    logic       scan_mode = 1'b0;
    logic       scan_din = 1'b0;
    logic [2:0] count_q;
    logic       scan_dout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scnt_top u_scnt_top (
        .clk       (clk),
        .cnt_en    (cnt_en),
        .sync_clr  (sync_clr),
        .scan_mode (scan_mode),
        .scan_din  (scan_din),
        .count_q   (count_q),
        .scan_dout (scan_dout)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive on falling edge, return 1 time unit after the rising edge
    task automatic step(input logic en, input logic clr, input logic se, input logic si);
        @(negedge clk);
        cnt_en = en; sync_clr = clr; scan_mode = se; scan_din = si;
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [2:0] v);
        for (int i = 2; i >= 0; i--) step(1'b0, 1'b0, 1'b1, v[i]);
    endtask

    task automatic t_reset();
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R1 reset state", count_q, 0);
        check("R5 reset scan_dout", scan_dout, 0);
    endtask

    task automatic t_count();
        logic [2:0] exp = 3'd0;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0);
            exp = exp + 3'd1;
            check("R2 count/wrap", count_q, exp);
            check("R5 dout tracks bit2", scan_dout, exp[2]);
        end
    endtask

    task automatic t_hold();
        logic [2:0] held = count_q;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1);
            check("R3 hold", count_q, held);
        end
    endtask

    task automatic t_shift();
        // enable high must not matter while shifting
        step(1'b1, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check("R4 shift order", count_q, 3'b100);
        check("R5 dout after shift", scan_dout, 1);
        step(1'b1, 1'b0, 1'b1, 1'b1);
        check("R4 shift out", count_q, 3'b001);
    endtask

    task automatic t_clear_override();
        load(3'b111);
        check("R4 load 7", count_q, 7);
        step(1'b1, 1'b1, 1'b1, 1'b1);
        check("R1 clear over shift", count_q, 0);
        load(3'b101);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R1 clear over count", count_q, 0);
    endtask

    task automatic t_capture();
        for (int en = 0; en < 2; en++) begin
            for (int v = 0; v < 8; v++) begin
                logic [2:0] exp;
                exp = (en != 0) ? 3'(v + 1) : 3'(v);
                load(3'(v));
                step(en[0], 1'b0, 1'b0, 1'b0);
                check("R6 capture", count_q, exp);
                check("R7 unload bit2", scan_dout, exp[2]);
                step(1'b0, 1'b0, 1'b1, 1'b0);
                check("R7 unload bit1", scan_dout, exp[1]);
                step(1'b0, 1'b0, 1'b1, 1'b0);
                check("R7 unload bit0", scan_dout, exp[0]);
            end
        end
    endtask

    initial begin
        t_reset();
        t_count();
        t_hold();
        t_shift();
        t_clear_override();
        t_capture();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule